// File: doc/BRIEF.md
# CPU Intermittent Clock Pause Generator

This block slows a CPU while the peripherals keep their full speed. The peripheral clock never stops. The block produces a registered enable for the CPU clock. Each time the CPU asks to start an internal bus cycle, the block holds that enable low for a fixed number of peripheral clock cycles. It then grants the cycle start for one clock. The internal bus cycles covered are register, internal memory, I/O and resource accesses.

Execution time therefore grows by one fixed pause per access. A 2-bit select chooses the pause length. The select is sampled only when a request is accepted, so changing it during a pause has no effect on that pause. An access flagged as external runs with no pause, because the external bus keeps the peripheral clock timing.

Top module: `cig_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cpu_clk_en` is 1 and `cyc_grant` is 0.
- R2: When no pause is running and `cyc_req` is 0, the next cycle shows `cpu_clk_en` = 1 and `cyc_grant` = 0.
- R3: The pause length is set by `pause_sel`: code 2'b00 gives 0 cycles (intermittent operation off), 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32.
- R4: A request is accepted at a clock edge where `cyc_req` is 1 and no pause is running. For a pause length N > 0, `cpu_clk_en` is then 0 for exactly N consecutive cycles, starting in the cycle after the accepting edge.
- R5: Once those N cycles have passed, `cyc_grant` is 1 for exactly one cycle, and `cpu_clk_en` is 1 in that cycle.
- R6: A request accepted with pause length 0 is granted in the next cycle, and `cpu_clk_en` stays 1.
- R7: A request accepted with `ext_acc` = 1 gets a pause length of 0, whatever the value of `pause_sel`.
- R8: `pause_sel` and `ext_acc` are sampled only at the accepting edge. Changes to them while a pause runs do not alter that pause.
- R9: `cyc_req` has no effect while a pause runs, so holding it high does not restart the count. A request still high in the grant cycle is accepted at the next edge as a new access, which gives back-to-back pauses.
- R10: `cpu_clk_en` and `cyc_grant` come straight from flip-flops clocked by `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock, which runs all the time |
| rst | input | 1 | Synchronous reset, active high |
| pause_sel | input | 2 | Selects the pause length |
| cyc_req | input | 1 | CPU request to start an internal bus cycle |
| ext_acc | input | 1 | The requested access uses the external bus |
| cpu_clk_en | output | 1 | Registered enable for the CPU clock |
| cyc_grant | output | 1 | One-cycle grant that lets the bus cycle start |

## Verification
Two functions can fall in the same cycle: a new request being accepted, and either a select change or the grant of the previous access. The bench moves `pause_sel` on the same edge that presents a request, and expects the new code to set the pause. It also changes the select in the middle of a pause, and expects no effect. It keeps `cyc_req` high through a grant cycle and expects a second full pause to start at once. A behavioural model in the bench runs alongside the design and is compared with it on every clock. Each pause length is also measured in cycles and checked against the fixed values 0, 8, 16 and 32.

// File: rtl/cig_pkg.sv
package cig_pkg;

    typedef enum logic [1:0] {
        GAP_OFF   = 2'b00,
        GAP_SHORT = 2'b01,
        GAP_MID   = 2'b10,
        GAP_LONG  = 2'b11
    } gap_sel_e;

    typedef struct packed {
        logic clk_en;
        logic grant;
    } gate_out_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/cig_gap_decode.sv
module cig_gap_decode
    import cig_pkg::*;
#(
    parameter int unsigned GAP_A = 8,
    parameter int unsigned GAP_B = 16,
    parameter int unsigned GAP_C = 32,
    parameter int unsigned CNT_W = 6
) (
    input  logic [1:0]       sel,
    input  logic             ext,
    output logic [CNT_W-1:0] len
);
    always_comb begin
        if (ext) begin
            len = '0;
        end else begin
            unique case (gap_sel_e'(sel))
                GAP_OFF:   len = '0;
                GAP_SHORT: len = CNT_W'(GAP_A);
                GAP_MID:   len = CNT_W'(GAP_B);
                GAP_LONG:  len = CNT_W'(GAP_C);
                default:   len = '0;
            endcase
        end
    end
endmodule

// File: rtl/cig_gap_counter.sv
module cig_gap_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             busy,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);
    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/cig_gate_reg.sv
module cig_gate_reg
    import cig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      zero_len,
    input  logic      busy,
    input  logic      last,
    output gate_out_t q
);
    gate_out_t d;

    always_comb begin
        d.clk_en = !((accept && !zero_len) || (busy && !last));
        d.grant  = (accept && zero_len) || last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.clk_en <= 1'b1;
            q.grant  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cig_top.sv
module cig_top
    import cig_pkg::*;
#(
    parameter int unsigned GAP_A = 8,
    parameter int unsigned GAP_B = 16,
    parameter int unsigned GAP_C = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pause_sel,
    input  logic       cyc_req,
    input  logic       ext_acc,
    output logic       cpu_clk_en,
    output logic       cyc_grant
);
    localparam int unsigned MAX_GAP = max3(GAP_A, GAP_B, GAP_C);
    localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);

    logic [CNT_W-1:0] gap_len;
    logic [CNT_W-1:0] cnt_q;
    logic             busy;
    logic             last;
    logic             accept;
    gate_out_t        gate_q;

    assign accept = cyc_req && !busy;

    cig_gap_decode #(
        .GAP_A(GAP_A), .GAP_B(GAP_B), .GAP_C(GAP_C), .CNT_W(CNT_W)
    ) u_dec (
        .sel (pause_sel),
        .ext (ext_acc),
        .len (gap_len)
    );

    cig_gap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (gap_len),
        .cnt      (cnt_q),
        .busy     (busy),
        .last     (last)
    );

    cig_gate_reg u_gate (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .zero_len (gap_len == '0),
        .busy     (busy),
        .last     (last),
        .q        (gate_q)
    );

    assign cpu_clk_en = gate_q.clk_en;
    assign cyc_grant  = gate_q.grant;
endmodule

// File: rtl/cig_chk.sv
module cig_chk #(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MAX_GAP = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       pause_sel,
    input logic             cyc_req,
    input logic             ext_acc,
    input logic             cpu_clk_en,
    input logic             cyc_grant,
    input logic [CNT_W-1:0] cnt_q
);
    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (cpu_clk_en && !cyc_grant));

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !cyc_req) |=> (cpu_clk_en && !cyc_grant));

    // R5
    grant_en_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_grant |-> cpu_clk_en);

    // R6
    off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && cyc_req && pause_sel == 2'b00) |=> (cyc_grant && cpu_clk_en));

    // R7
    ext_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && cyc_req && ext_acc) |=> (cyc_grant && cpu_clk_en));

    // R4
    fall_req_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk_en) |-> $past(cyc_req));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_GAP));
endmodule

bind cig_top cig_chk #(.CNT_W(CNT_W), .MAX_GAP(MAX_GAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pause_sel  (pause_sel),
    .cyc_req    (cyc_req),
    .ext_acc    (ext_acc),
    .cpu_clk_en (cpu_clk_en),
    .cyc_grant  (cyc_grant),
    .cnt_q      (cnt_q)
);

// File: tb/tb_cig_top.sv
`timescale 1ns/1ps
module tb_cig_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pause_sel = 2'b00;
    logic       cyc_req = 1'b0;
    logic       ext_acc = 1'b0;
    logic       cpu_clk_en;
    logic       cyc_grant;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference model
    int m_rem = 0;
    bit m_en = 1'b1;
    bit m_gr = 1'b0;

    always #2.5 clk = ~clk;

    cig_top dut (
        .clk(clk), .rst(rst), .pause_sel(pause_sel), .cyc_req(cyc_req),
        .ext_acc(ext_acc), .cpu_clk_en(cpu_clk_en), .cyc_grant(cyc_grant)
    );

    function automatic int exp_gap(input logic [1:0] s, input logic e);
        if (e) return 0;
        case (s)
            2'b00: return 0;
            2'b01: return 8;
            2'b10: return 16;
            default: return 32;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0; m_en = 1'b1; m_gr = 1'b0;
        end else if (m_rem == 0 && cyc_req) begin
            m_rem = exp_gap(pause_sel, ext_acc);
            m_gr  = (m_rem == 0);
            m_en  = (m_rem == 0);
        end else if (m_rem > 0) begin
            m_rem = m_rem - 1;
            m_gr  = (m_rem == 0);
            m_en  = (m_rem == 0);
        end else begin
            m_gr = 1'b0; m_en = 1'b1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R10 lockstep comparison of both registered outputs on every clock
    always @(negedge clk) begin
        if (!rst) begin
            check("R10 cpu_clk_en lockstep", int'(cpu_clk_en), int'(m_en));
            check("R10 cyc_grant lockstep", int'(cyc_grant), int'(m_gr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // one access: request, count enable-low cycles until the grant
    task automatic access(input logic [1:0] s, input logic e, input int exp,
                          input int chg_at, input string tag);
        int low = 0;
        int n = 0;
        @(negedge clk);
        pause_sel = s; ext_acc = e; cyc_req = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (n == chg_at) begin
                pause_sel = ~s; ext_acc = ~e;
            end
            if (cyc_grant) break;
            if (!cpu_clk_en) low++;
            if (n > 100) break;
        end
        check({tag, " pause length"}, low, exp);
        check({tag, " grant with enable"}, int'(cpu_clk_en), 1);
        cyc_req = 1'b0; ext_acc = 1'b0;
        @(negedge clk);
        check({tag, " grant single cycle"}, int'(cyc_grant), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset enable", int'(cpu_clk_en), 1);
        check("R1 reset grant", int'(cyc_grant), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset enable", int'(cpu_clk_en), 1);
        repeat (3) @(negedge clk);
        // R2
        check("R2 idle enable", int'(cpu_clk_en), 1);
        check("R2 idle grant", int'(cyc_grant), 0);

        // R3 R4 R5: each code, new select presented with the request
        access(2'b01, 1'b0, 8,  0, "R3 code01");
        access(2'b10, 1'b0, 16, 0, "R4 code10");
        access(2'b11, 1'b0, 32, 0, "R5 code11");
        // R6
        access(2'b00, 1'b0, 0,  0, "R6 code00");
        // R7
        access(2'b11, 1'b1, 0,  0, "R7 external");
        access(2'b01, 1'b1, 0,  0, "R7 external short");
        // R8: select and external flag flip mid-pause
        access(2'b01, 1'b0, 8,  3, "R8 mid change short");
        access(2'b11, 1'b0, 32, 5, "R8 mid change long");

        // R9: request held high across a grant gives back-to-back pauses
        begin
            int low = 0;
            int grants = 0;
            @(negedge clk);
            pause_sel = 2'b01; cyc_req = 1'b1;
            for (int i = 0; i < 18; i++) begin
                @(negedge clk);
                if (cyc_grant) grants++;
                else if (!cpu_clk_en) low++;
            end
            check("R9 back-to-back grants", grants, 2);
            check("R9 back-to-back low cycles", low, 16);
            @(negedge clk);
            check("R9 third pause started", int'(cpu_clk_en), 0);
            cyc_req = 1'b0;
            repeat (10) @(negedge clk);
            check("R9 enable restored", int'(cpu_clk_en), 1);
        end

        // R1: reset in the middle of a pause
        @(negedge clk);
        pause_sel = 2'b10; cyc_req = 1'b1;
        @(negedge clk);
        cyc_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-pause enable", int'(cpu_clk_en), 1);
        check("R1 reset mid-pause grant", int'(cyc_grant), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 idle after reset", int'(cpu_clk_en), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule